// File: doc/BRIEF.md
# Serial Audio Slot Transmitter

This block is one transmit lane of a time-division multiplexed serial audio port. Software places a sample in a holding register. At each frame start, if the lane is enabled, the sample moves into a shift register. The block then drives that sample onto the serial data pin during one slot of `SLOT_BITS` bit periods. A bit period advances on each cycle where the one-cycle `bit_tick` strobe is high. That strobe marks the edge of the bit clock opposite to the one where the far end samples, so the pin changes away from the sampling edge. The bit clock, the frame sync, the receive path and interrupts all come from outside the block.

The sample can be `WORD_BITS` wide, shorter than the slot, for example 24 bits in a 32-bit slot. Three format controls set how it is sent:
- **Bit order:** most significant bit first or least significant bit first.
- **Alignment:** the sample sits at the start of the slot or at its end.
- **Fill:** the spare slot bits are zeros, or a copy of the nearest data bit.

Enabling takes effect only at a frame start. Disabling always lets the current slot finish. Outside its slot the lane releases the pin: `sd_oe` low means high impedance.

Top module: `sat_lane_tx`

## Requirements
- R1: After reset, `sd_oe` is 0, `sd_out` is 0 and `tx_empty` is 1.
- R2: A clock edge with `bit_tick`, `frame_sync` and `tx_enable` all high starts a slot. From the next cycle, `sd_oe` is 1 for exactly `SLOT_BITS` bit periods, and each later `bit_tick` moves to the next slot bit. After the tick that ends the last bit, `sd_oe` returns to 0 unless that same tick starts a new slot.
- R3: `tx_empty` goes to 1 when the holding register is transferred at a slot start, and goes to 0 when `wr_en` writes it. If a write lands on the same edge as a transfer, the old word is sent and the new word is kept, with `tx_empty` at 0.
- R4: A frame start with `tx_enable` low starts no slot. The holding register is still written by `wr_en`, keeps its word and leaves `tx_empty` unchanged. That word is sent at the first enabled frame start.
- R5: Clearing `tx_enable` during a slot lets that slot finish with all of its bits. A frame start while `tx_enable` is low then sends nothing.
- R6: Clearing and setting `tx_enable` again during a slot still lets the slot end normally. The pin then stays released until the next frame start, even though the enable is high.
- R7: With `fmt_lsb_first` at 0 the data bits go out from bit `WORD_BITS-1` down to bit 0. With it at 1 they go out from bit 0 up.
- R8: With `fmt_right_align` at 0 the data occupy slot positions 0 to `WORD_BITS-1`. The remaining positions are 0 when `fmt_zero_pad` is 1, or repeat the last data bit sent when it is 0.
- R9: With `fmt_right_align` at 1 the data occupy the last `WORD_BITS` slot positions. The leading positions are 0 when `fmt_zero_pad` is 1, or repeat the first data bit to be sent when it is 0.
- R10: If the holding register is not rewritten between two enabled frame starts, the same word is sent again.
- R11: The three format controls are taken at the slot start. Changing them during a slot does not alter that slot's bits.
- R12: `sd_out` is 0 whenever `sd_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe marking a transmit bit edge |
| frame_sync | input | 1 | Frame start, qualified by `bit_tick` |
| tx_enable | input | 1 | Lane enable |
| fmt_lsb_first | input | 1 | 0 = MSB first, 1 = LSB first |
| fmt_right_align | input | 1 | 0 = word at start of slot, 1 = word at end of slot |
| fmt_zero_pad | input | 1 | 1 = spare bits are zero, 0 = spare bits repeat a data bit |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | WORD_BITS | Word to write |
| tx_empty | output | 1 | Holding register has been consumed |
| sd_out | output | 1 | Serial data value |
| sd_oe | output | 1 | Serial data drive enable (0 = high impedance) |

## Verification
Some properties are checked by the assertions on every cycle:
- the empty flag's response to transfers and writes, and that the held word stays unchanged between writes;
- the slot position bound;
- the latched format staying fixed through a slot;
- the lane staying idle until a frame start;
- a quiet pin whenever the drive is off;
- an unchanging pin through repeated-bit fill runs.

Other behaviours need the bench's scenarios: the bit values in each slot position for every format combination, resending an unchanged word, the write/transfer collision, and the enable being dropped or pulsed during a slot.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef struct packed {
    logic lsb_first;
    logic right_align;
    logic zero_pad;
  } sat_fmt_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_DATA = 2'd2,
    PH_TAIL = 2'd3
  } sat_phase_e;

endpackage

// File: rtl/sat_holding.sv
module sat_holding #(
  parameter int WORD_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [WORD_BITS-1:0] wr_data,
  input  logic                 take,
  output logic [WORD_BITS-1:0] hold_q,
  output logic                 empty
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      empty  <= 1'b1;
    end else begin
      if (wr_en) hold_q <= wr_data;
      // a write on the transfer edge wins: the new word stays pending
      if (wr_en)     empty <= 1'b0;
      else if (take) empty <= 1'b1;
    end
  end

  p_take_sets_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !wr_en) |=> empty);

  p_write_clears_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !empty);

  p_hold_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(hold_q));

endmodule

// File: rtl/sat_slot_seq.sv
module sat_slot_seq
  import sat_pkg::*;
#(
  parameter int WORD_BITS = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_tick,
  input  logic        frame_sync,
  input  logic        enable,
  input  sat_fmt_t    fmt_in,
  output logic        start_evt,
  output logic        step_evt,
  output logic        done_evt,
  output logic        shift_evt,
  output logic        active,
  output sat_phase_e  phase,
  output sat_fmt_t    fmt_q
);

  localparam int POS_W    = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam int PAD_BITS = SLOT_BITS - WORD_BITS;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_BITS - 1);

  logic [POS_W-1:0] pos;
  logic             at_last;

  // phase of a slot position for a given alignment
  function automatic sat_phase_e phase_of(input logic [POS_W-1:0] p,
                                          input logic right);
    int pi;
    pi = int'(p);
    if (right) return (pi < PAD_BITS)  ? PH_LEAD : PH_DATA;
    else       return (pi < WORD_BITS) ? PH_DATA : PH_TAIL;
  endfunction

  assign at_last   = active && (pos == LAST_POS);
  assign start_evt = bit_tick && frame_sync && enable;
  assign done_evt  = bit_tick && at_last && !start_evt;
  assign step_evt  = bit_tick && active && !at_last && !start_evt;
  assign phase     = active ? phase_of(pos, fmt_q.right_align) : PH_IDLE;
  assign shift_evt = step_evt && (phase == PH_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pos    <= '0;
      fmt_q  <= '0;
    end else if (start_evt) begin
      active <= 1'b1;
      pos    <= '0;
      fmt_q  <= fmt_in;
    end else if (done_evt) begin
      active <= 1'b0;
      pos    <= '0;
    end else if (step_evt) begin
      pos    <= pos + 1'b1;
    end
  end

  p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (int'(pos) < SLOT_BITS));

  p_fmt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start_evt) |=> $stable(fmt_q));

  p_idle_until_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(bit_tick && frame_sync)) |=> !active);

  initial begin
    if (WORD_BITS < 1 || WORD_BITS > SLOT_BITS || SLOT_BITS < 2)
      $error("sat_slot_seq: need 1 <= WORD_BITS <= SLOT_BITS, SLOT_BITS >= 2");
  end

endmodule

// File: rtl/sat_shifter.sv
module sat_shifter
  import sat_pkg::*;
#(
  parameter int WORD_BITS = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] load_word,
  input  logic                 shift,
  input  sat_phase_e           phase,
  input  sat_fmt_t             fmt,
  output logic                 bit_out
);

  logic [WORD_BITS-1:0] sh;
  logic                 last_bit;
  logic                 head;

  // bit at the sending end of the register
  function automatic logic head_of(input logic [WORD_BITS-1:0] v,
                                   input logic lsb);
    return lsb ? v[0] : v[WORD_BITS-1];
  endfunction

  function automatic logic [WORD_BITS-1:0] advance(input logic [WORD_BITS-1:0] v,
                                                   input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  assign head = head_of(sh, fmt.lsb_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      last_bit <= 1'b0;
    end else if (load) begin
      sh       <= load_word;
      last_bit <= 1'b0;
    end else if (shift) begin
      last_bit <= head;
      sh       <= advance(sh, fmt.lsb_first);
    end
  end

  always_comb begin
    unique case (phase)
      PH_DATA: bit_out = head;
      PH_LEAD: bit_out = fmt.zero_pad ? 1'b0 : head;
      PH_TAIL: bit_out = fmt.zero_pad ? 1'b0 : last_bit;
      default: bit_out = 1'b0;
    endcase
  end

  p_tail_repeat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TAIL && $past(phase == PH_TAIL) && !fmt.zero_pad) |-> $stable(bit_out));

  p_lead_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LEAD && $past(phase == PH_LEAD) && !fmt.zero_pad) |-> $stable(bit_out));

endmodule

// File: rtl/sat_lane_tx.sv
module sat_lane_tx
  import sat_pkg::*;
#(
  parameter int WORD_BITS = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_tick,
  input  logic                 frame_sync,
  input  logic                 tx_enable,
  input  logic                 fmt_lsb_first,
  input  logic                 fmt_right_align,
  input  logic                 fmt_zero_pad,
  input  logic                 wr_en,
  input  logic [WORD_BITS-1:0] wr_data,
  output logic                 tx_empty,
  output logic                 sd_out,
  output logic                 sd_oe
);

  sat_fmt_t             fmt_in;
  sat_fmt_t             fmt_q;
  sat_phase_e           phase;
  logic                 start_evt;
  logic                 step_evt;
  logic                 done_evt;
  logic                 shift_evt;
  logic                 active;
  logic [WORD_BITS-1:0] hold_q;
  logic                 bit_val;

  assign fmt_in = '{lsb_first: fmt_lsb_first,
                    right_align: fmt_right_align,
                    zero_pad: fmt_zero_pad};

  sat_holding #(.WORD_BITS(WORD_BITS)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (start_evt),
    .hold_q  (hold_q),
    .empty   (tx_empty)
  );

  sat_slot_seq #(.WORD_BITS(WORD_BITS), .SLOT_BITS(SLOT_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_tick   (bit_tick),
    .frame_sync (frame_sync),
    .enable     (tx_enable),
    .fmt_in     (fmt_in),
    .start_evt  (start_evt),
    .step_evt   (step_evt),
    .done_evt   (done_evt),
    .shift_evt  (shift_evt),
    .active     (active),
    .phase      (phase),
    .fmt_q      (fmt_q)
  );

  sat_shifter #(.WORD_BITS(WORD_BITS)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_evt),
    .load_word (hold_q),
    .shift     (shift_evt),
    .phase     (phase),
    .fmt       (fmt_q),
    .bit_out   (bit_val)
  );

  assign sd_oe  = active;
  assign sd_out = bit_val;

  p_quiet_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_oe |-> !sd_out);

  p_release_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sd_oe) |-> $past(done_evt));

  p_step_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt || done_evt) |-> bit_tick);

endmodule

// File: tb/test_sat_lane_tx.sv
module test_sat_lane_tx;

  localparam int W = 6;
  localparam int S = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bit_tick = 1'b0;
  logic         frame_sync = 1'b0;
  logic         tx_enable = 1'b0;
  logic         fmt_lsb_first = 1'b0;
  logic         fmt_right_align = 1'b0;
  logic         fmt_zero_pad = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         tx_empty;
  logic         sd_out;
  logic         sd_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sat_lane_tx #(.WORD_BITS(W), .SLOT_BITS(S)) i_sat_lane_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .frame_sync(frame_sync),
    .tx_enable(tx_enable), .fmt_lsb_first(fmt_lsb_first),
    .fmt_right_align(fmt_right_align), .fmt_zero_pad(fmt_zero_pad),
    .wr_en(wr_en), .wr_data(wr_data), .tx_empty(tx_empty),
    .sd_out(sd_out), .sd_oe(sd_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected slot bit; cfg[0]=lsb first, cfg[1]=right align, cfg[2]=zero fill
  function automatic int exp_bit(input logic [W-1:0] w, input int p, input int cfg);
    int d;
    bit lsb, right, zp;
    lsb = cfg[0]; right = cfg[1]; zp = cfg[2];
    d = right ? p - (S - W) : p;
    if (d >= 0 && d < W) return lsb ? int'(w[d]) : int'(w[W-1-d]);
    if (zp) return 0;
    if (d < 0) return lsb ? int'(w[0]) : int'(w[W-1]);
    return lsb ? int'(w[W-1]) : int'(w[0]);
  endfunction

  task automatic set_cfg(input int cfg);
    fmt_lsb_first   = cfg[0];
    fmt_right_align = cfg[1];
    fmt_zero_pad    = cfg[2];
  endtask

  task automatic tick(input bit fs);
    @(negedge clk); bit_tick = 1'b1; frame_sync = fs;
    @(negedge clk); bit_tick = 1'b0; frame_sync = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_word(input logic [W-1:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // act: 0 none, 1 clear enable, 2 clear then set again, 3 flip format
  task automatic slot_body(input logic [W-1:0] w, input int cfg, input int act, input int at);
    string tag;
    tag = cfg[1] ? "R9" : "R8";
    if (cfg[0]) tag = {tag, "/R7"};
    for (int p = 0; p < S; p++) begin
      check("R2 drive on in slot", sd_oe, 1);
      check(tag, sd_out, exp_bit(w, p, cfg));
      if (act == 1 && p == at) tx_enable = 1'b0;
      if (act == 2 && p == at) tx_enable = 1'b0;
      if (act == 2 && p == at + 2) tx_enable = 1'b1;
      if (act == 3 && p == at) set_cfg(~cfg & 7);
      tick(1'b0);
    end
    check("R2 release after slot", sd_oe, 0);
    check("R12 quiet pin", sd_out, 0);
  endtask

  task automatic run_frame(input logic [W-1:0] w, input int cfg, input int act, input int at);
    set_cfg(cfg);
    tx_enable = 1'b1;
    tick(1'b1);
    check("R3 empty after transfer", tx_empty, 1);
    slot_body(w, cfg, act, at);
  endtask

  initial begin
    logic [W-1:0] pats [4];
    pats[0] = 6'h2D; pats[1] = 6'h13; pats[2] = 6'h3E; pats[3] = 6'h01;

    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe", sd_oe, 0);
    check("R1 out", sd_out, 0);
    check("R1 empty", tx_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 R8 R9: every format with several words
    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int k = 0; k < 4; k++) begin
        write_word(pats[k]);
        check("R3 write clears empty", tx_empty, 0);
        run_frame(pats[k], cfg, 0, 0);
      end
    end

    // R10 resend without rewrite
    run_frame(pats[3], 0, 0, 0);
    run_frame(pats[3], 3, 0, 0);

    // R3 write on the transfer edge
    write_word(6'h15);
    set_cfg(0); tx_enable = 1'b1;
    @(negedge clk); bit_tick = 1'b1; frame_sync = 1'b1; wr_en = 1'b1; wr_data = 6'h2A;
    @(negedge clk); bit_tick = 1'b0; frame_sync = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    check("R3 collision keeps new pending", tx_empty, 0);
    slot_body(6'h15, 0, 0, 0);
    run_frame(6'h2A, 0, 0, 0);

    // R4 disabled lane: writes held, no slot
    tx_enable = 1'b0;
    write_word(6'h27);
    tick(1'b1);
    check("R4 no slot when disabled", sd_oe, 0);
    check("R4 empty unchanged", tx_empty, 0);
    tick(1'b0);
    check("R4 still released", sd_oe, 0);
    run_frame(6'h27, 4, 0, 0);

    // R5 clear enable mid-slot: slot completes, next frame silent
    write_word(6'h39);
    run_frame(6'h39, 1, 1, 2);
    tick(1'b1);
    check("R5 silent after disable", sd_oe, 0);

    // R6 clear and set again mid-slot: released until next frame start
    write_word(6'h0B);
    run_frame(6'h0B, 2, 2, 1);
    for (int i = 0; i < 3; i++) begin
      tick(1'b0);
      check("R6 released until frame start", sd_oe, 0);
    end
    run_frame(6'h0B, 2, 0, 0);

    // R11 format changes during a slot ignored
    write_word(6'h31);
    run_frame(6'h31, 5, 3, 1);
    write_word(6'h1C);
    run_frame(6'h1C, 2, 3, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule